// File: doc/BRIEF.md
# Multi-Sensor Temperature Threshold Monitor

This block watches a set of digital temperature readings, one stream per sensor, and raises a single interrupt request when any reading crosses its programmed window. Each sensor has a 10-bit lower and a 10-bit upper threshold. Each has the last reading it captured, and four violation flags: at/below lower, at/above upper, new minimum, new maximum. The lower and upper flags are sticky and drive the interrupt. Software clears them by writing one to a clear bit in the same word that carries the thresholds. After each interrupt it usually programs a new window in that same word.

A small word-addressed register port gives access to the control, interrupt-enable, ready, per-sensor threshold and per-sensor status words. Reads return data one cycle after the request. Readings come in on a per-sensor valid/data pair. They are taken only while the monitor is enabled. A software-reset bit in the control word returns every sensor to its initial state without touching the enables.

Top module: `thermal_watch`

## Requirements
- R1: After `rst`, every status word reads 0, every threshold word reads 0x000FFC00 (lower 0, upper 0x3FF), the control, interrupt-enable and ready words read 0, and `irq` is 0.
- R2: Register addresses (6-bit word address): 0x00 control (bit 0 monitor enable, bit 1 software reset, which reads back 0), 0x01 interrupt enable (bit 0), 0x02 ready (bit 0). 0x10+n is the threshold word of sensor n, and 0x20+n is its status word.
- R3: Status word layout: bits 9:0 last reading, bit 10 min flag, bit 11 lower flag, bit 12 upper flag, bit 13 max flag. A valid sample is captured only while control bit 0 is 1. While it is 0, samples change no status word.
- R4: A captured reading less than or equal to the sensor's lower threshold sets its lower flag.
- R5: A captured reading greater than or equal to the sensor's upper threshold sets its upper flag.
- R6: Threshold word layout: bits 9:0 lower, bits 19:10 upper, bit 20 clears the lower flag, bit 21 clears the upper flag (read back as 0). Lower and upper flags stay set until cleared this way. A write with a clear bit at 0 leaves that flag alone.
- R7: Each captured reading sets the min flag to 1 if it is the first since reset or strictly below every earlier one, else 0. The max flag works the same way for strictly above.
- R8: `irq` is 1 exactly when the interrupt enable is 1 and some sensor has its lower or upper flag set. It follows the flags one cycle later.
- R9: Writing control bit 1 clears all readings, flags and the ready bit, and restores thresholds to lower 0 and upper 0x3FF. Control bit 0 takes the written value and the interrupt enable is kept.
- R10: The ready bit reads 1 once every sensor has captured a reading since the last reset, and 0 before that.
- R11: Read data is valid one cycle after `reg_re`. Unmapped addresses, including sensor indices at or above the sensor count, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 6 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| samp_vld | input | NUM_SENS | Per-sensor sample valid |
| samp_temp | input | NUM_SENS*10 | Per-sensor sample values, sensor n at bits 10n+9:10n |
| irq | output | 1 | Threshold interrupt request, registered |

## Verification
The assertions take for granted that the register port carries one access per cycle. They also assume a sample is compared against the thresholds held before that edge, so a threshold write and a sample for the same sensor in one cycle give no defined ordering for a checker to rely on. The stimulus keeps register writes and samples in separate cycles, and runs one random operation at a time: a sample, a threshold write with random clear bits, a read or an enable toggle. Directed cases put readings exactly on the thresholds and issue a software reset while flags are set and the interrupt is pending.

// File: rtl/tmon_pkg.sv
package tmon_pkg;
  localparam int ADDR_W = 6;
  localparam int IDX_W  = 4;
  localparam int DW     = 32;

  localparam logic [1:0] RGN_GLOB = 2'd0;
  localparam logic [1:0] RGN_THR  = 2'd1;
  localparam logic [1:0] RGN_STAT = 2'd2;

  localparam logic [IDX_W-1:0] OFF_CTRL = 4'd0;
  localparam logic [IDX_W-1:0] OFF_IEN  = 4'd1;
  localparam logic [IDX_W-1:0] OFF_RDY  = 4'd2;

  // packed so that fmin lands just above the reading in the status word
  typedef struct packed {
    logic fmax;
    logic fhi;
    logic flo;
    logic fmin;
  } flags_t;
endpackage

// File: rtl/tmon_chan.sv
module tmon_chan #(
  parameter int TW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_all,
  input  logic              mon_en,
  input  logic              thr_we,
  input  logic [2*TW+1:0]   thr_wd,
  input  logic              s_vld,
  input  logic [TW-1:0]     s_temp,
  output logic [TW-1:0]     lo_thr,
  output logic [TW-1:0]     hi_thr,
  output logic [TW-1:0]     last_temp,
  output tmon_pkg::flags_t  flags,
  output logic              seen
);
  localparam int CLR_LO = 2 * TW;
  localparam int CLR_HI = 2 * TW + 1;

  logic [TW-1:0] run_min, run_max;
  logic          new_min, new_max, take;

  always_comb begin
    take    = mon_en && s_vld;
    new_min = !seen || (s_temp < run_min);
    new_max = !seen || (s_temp > run_max);
  end

  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      lo_thr    <= '0;
      hi_thr    <= '1;
      last_temp <= '0;
      flags     <= '0;
      seen      <= 1'b0;
      run_min   <= '1;
      run_max   <= '0;
    end else begin
      if (thr_we) begin
        lo_thr <= thr_wd[TW-1:0];
        hi_thr <= thr_wd[2*TW-1:TW];
        if (thr_wd[CLR_LO]) flags.flo <= 1'b0;
        if (thr_wd[CLR_HI]) flags.fhi <= 1'b0;
      end
      if (take) begin
        last_temp  <= s_temp;
        seen       <= 1'b1;
        flags.fmin <= new_min;
        flags.fmax <= new_max;
        if (new_min) run_min <= s_temp;
        if (new_max) run_max <= s_temp;
        // a fresh violation wins over a clear in the same cycle
        if (s_temp <= lo_thr) flags.flo <= 1'b1;
        if (s_temp >= hi_thr) flags.fhi <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tmon_rdmux.sv
module tmon_rdmux #(
  parameter int NS = 11,
  parameter int TW = 10
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          re,
  input  logic [tmon_pkg::ADDR_W-1:0]   addr,
  input  logic                          en_q,
  input  logic                          ien_q,
  input  logic                          ready,
  input  logic [NS-1:0][TW-1:0]         lo_thr,
  input  logic [NS-1:0][TW-1:0]         hi_thr,
  input  logic [NS-1:0][TW+3:0]         stat,
  output logic [tmon_pkg::DW-1:0]       rdata
);
  import tmon_pkg::*;

  logic [1:0]       rgn;
  logic [IDX_W-1:0] idx;
  logic             idx_ok;
  logic [DW-1:0]    nxt;

  always_comb begin
    rgn    = addr[ADDR_W-1:IDX_W];
    idx    = addr[IDX_W-1:0];
    idx_ok = (int'(idx) < NS);
    nxt    = '0;
    case (rgn)
      RGN_GLOB: begin
        case (idx)
          OFF_CTRL: nxt[0] = en_q;
          OFF_IEN:  nxt[0] = ien_q;
          OFF_RDY:  nxt[0] = ready;
          default:  nxt = '0;
        endcase
      end
      RGN_THR:  if (idx_ok) nxt[2*TW-1:0] = {hi_thr[idx], lo_thr[idx]};
      RGN_STAT: if (idx_ok) nxt[TW+3:0]   = stat[idx];
      default:  nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= nxt;
  end
endmodule

// File: rtl/thermal_watch.sv
module thermal_watch #(
  parameter int NUM_SENS = 11,
  parameter int TW       = 10
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       reg_we,
  input  logic                       reg_re,
  input  logic [5:0]                 reg_addr,
  input  logic [31:0]                reg_wdata,
  output logic [31:0]                reg_rdata,
  input  logic [NUM_SENS-1:0]        samp_vld,
  input  logic [NUM_SENS*TW-1:0]     samp_temp,
  output logic                       irq
);
  import tmon_pkg::*;

  logic [1:0]                   rgn;
  logic [IDX_W-1:0]             idx;
  logic                         glob_we, srst;
  logic                         en_q, ien_q, ready;
  logic [NUM_SENS-1:0]          seen, lo_flag, hi_flag;
  logic [NUM_SENS-1:0][TW-1:0]  lo_thr, hi_thr, last_temp;
  logic [NUM_SENS-1:0][TW+3:0]  stat;
  flags_t [NUM_SENS-1:0]        flg;

  always_comb begin
    rgn     = reg_addr[ADDR_W-1:IDX_W];
    idx     = reg_addr[IDX_W-1:0];
    glob_we = reg_we && (rgn == RGN_GLOB);
    srst    = glob_we && (idx == OFF_CTRL) && reg_wdata[1];
    ready   = &seen;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      ien_q <= 1'b0;
      irq   <= 1'b0;
    end else begin
      if (glob_we && idx == OFF_CTRL) en_q  <= reg_wdata[0];
      if (glob_we && idx == OFF_IEN)  ien_q <= reg_wdata[0];
      irq <= ien_q && ((|lo_flag) || (|hi_flag));
    end
  end

  for (genvar i = 0; i < NUM_SENS; i++) begin : g_chan
    logic thr_we_i;
    assign thr_we_i = reg_we && (rgn == RGN_THR) && (int'(idx) == i);

    tmon_chan #(.TW(TW)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .clr_all   (srst),
      .mon_en    (en_q),
      .thr_we    (thr_we_i),
      .thr_wd    (reg_wdata[2*TW+1:0]),
      .s_vld     (samp_vld[i]),
      .s_temp    (samp_temp[i*TW +: TW]),
      .lo_thr    (lo_thr[i]),
      .hi_thr    (hi_thr[i]),
      .last_temp (last_temp[i]),
      .flags     (flg[i]),
      .seen      (seen[i])
    );

    assign stat[i]    = {flg[i], last_temp[i]};
    assign lo_flag[i] = flg[i].flo;
    assign hi_flag[i] = flg[i].fhi;
  end

  tmon_rdmux #(.NS(NUM_SENS), .TW(TW)) u_rd (
    .clk    (clk),
    .rst    (rst),
    .re     (reg_re),
    .addr   (reg_addr),
    .en_q   (en_q),
    .ien_q  (ien_q),
    .ready  (ready),
    .lo_thr (lo_thr),
    .hi_thr (hi_thr),
    .stat   (stat),
    .rdata  (reg_rdata)
  );
endmodule

// File: rtl/thermal_watch_sva.sv
module thermal_watch_sva #(
  parameter int NS = 11,
  parameter int TW = 10
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  reg_we,
  input logic [5:0]            reg_addr,
  input logic [31:0]           reg_wdata,
  input logic [NS-1:0]         samp_vld,
  input logic [NS*TW-1:0]      samp_temp,
  input logic                  en_q,
  input logic                  ien_q,
  input logic [NS-1:0][TW-1:0] lo_thr,
  input logic [NS-1:0][TW-1:0] hi_thr,
  input logic [NS-1:0]         lo_flag,
  input logic [NS-1:0]         hi_flag,
  input logic                  irq
);
  logic srst;
  assign srst = reg_we && (reg_addr == 6'h00) && reg_wdata[1];

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    !ien_q |=> !irq); // R8

  AST_SRST_THR: assert property (@(posedge clk) disable iff (rst)
    srst |=> (lo_thr[0] == '0) && (hi_thr[0] == '1)); // R9

  AST_SRST_IRQ: assert property (@(posedge clk) disable iff (rst)
    srst |=> ##1 !irq); // R9

  for (genvar i = 0; i < NS; i++) begin : g_s
    logic thr_wr, smp;
    assign thr_wr = reg_we && (reg_addr == 6'(16 + i));
    assign smp    = en_q && samp_vld[i] && !srst && !thr_wr;

    AST_LO_SET: assert property (@(posedge clk) disable iff (rst)
      (smp && samp_temp[i*TW +: TW] <= lo_thr[i]) |=> lo_flag[i]); // R4

    AST_HI_SET: assert property (@(posedge clk) disable iff (rst)
      (smp && samp_temp[i*TW +: TW] >= hi_thr[i]) |=> hi_flag[i]); // R5

    AST_LO_HOLD: assert property (@(posedge clk) disable iff (rst)
      (lo_flag[i] && !srst && !(thr_wr && reg_wdata[2*TW])) |=> lo_flag[i]); // R6

    AST_HI_HOLD: assert property (@(posedge clk) disable iff (rst)
      (hi_flag[i] && !srst && !(thr_wr && reg_wdata[2*TW+1])) |=> hi_flag[i]); // R6

    AST_OFF_STABLE: assert property (@(posedge clk) disable iff (rst)
      (!en_q && !srst && !thr_wr) |=> $stable(lo_flag[i]) && $stable(hi_flag[i])); // R3
  end
endmodule

bind thermal_watch thermal_watch_sva #(.NS(NUM_SENS), .TW(TW)) u_sva (
  .clk       (clk),
  .rst       (rst),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .samp_vld  (samp_vld),
  .samp_temp (samp_temp),
  .en_q      (en_q),
  .ien_q     (ien_q),
  .lo_thr    (lo_thr),
  .hi_thr    (hi_thr),
  .lo_flag   (lo_flag),
  .hi_flag   (hi_flag),
  .irq       (irq)
);

// File: tb/thermal_watch_tb.sv
module thermal_watch_tb;
  localparam int NS = 11;
  localparam int TW = 10;
  localparam int CLK_PERIOD = 10;
  localparam int MAXV = (1 << TW) - 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reg_we = 1'b0, reg_re = 1'b0;
  logic [5:0]        reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic [NS-1:0]     samp_vld = '0;
  logic [NS*TW-1:0]  samp_temp = '0;
  logic              irq;

  int n_chk = 0, n_fail = 0;

  // reference model
  int m_lo[NS], m_hi[NS], m_last[NS], m_rmin[NS], m_rmax[NS];
  bit m_fmin[NS], m_flo[NS], m_fhi[NS], m_fmax[NS], m_seen[NS];
  bit m_en, m_ien;

  always #(CLK_PERIOD/2) clk = ~clk;

  thermal_watch #(.NUM_SENS(NS), .TW(TW)) u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .samp_vld(samp_vld), .samp_temp(samp_temp), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic mdl_clear();
    for (int i = 0; i < NS; i++) begin
      m_lo[i] = 0; m_hi[i] = MAXV; m_last[i] = 0; m_rmin[i] = MAXV; m_rmax[i] = 0;
      m_fmin[i] = 0; m_flo[i] = 0; m_fhi[i] = 0; m_fmax[i] = 0; m_seen[i] = 0;
    end
  endtask

  function automatic logic [31:0] exp_stat(input int i);
    return 32'(m_last[i]) | (32'(m_fmin[i]) << 10) | (32'(m_flo[i]) << 11)
         | (32'(m_fhi[i]) << 12) | (32'(m_fmax[i]) << 13);
  endfunction

  function automatic logic [31:0] exp_thr(input int i);
    return 32'(m_lo[i]) | (32'(m_hi[i]) << 10);
  endfunction

  function automatic bit exp_irq();
    bit any = 0;
    for (int i = 0; i < NS; i++) any |= m_flo[i] | m_fhi[i];
    return m_ien & any;
  endfunction

  function automatic bit exp_ready();
    bit all = 1;
    for (int i = 0; i < NS; i++) all &= m_seen[i];
    return all;
  endfunction

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (a == 6'h00) begin
      m_en = d[0];
      if (d[1]) mdl_clear();
    end else if (a == 6'h01) m_ien = d[0];
    else if (a >= 6'h10 && a < 6'(16 + NS)) begin
      int i = int'(a) - 16;
      m_lo[i] = int'(d[9:0]); m_hi[i] = int'(d[19:10]);
      if (d[20]) m_flo[i] = 0;
      if (d[21]) m_fhi[i] = 0;
    end
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic samp(input int i, input int t);
    @(negedge clk);
    samp_vld[i] = 1'b1; samp_temp[i*TW +: TW] = TW'(t);
    @(negedge clk);
    samp_vld = '0;
    if (m_en) begin
      bit nmin = !m_seen[i] || t < m_rmin[i];
      bit nmax = !m_seen[i] || t > m_rmax[i];
      m_last[i] = t; m_seen[i] = 1;
      m_fmin[i] = nmin; m_fmax[i] = nmax;
      if (nmin) m_rmin[i] = t;
      if (nmax) m_rmax[i] = t;
      if (t <= m_lo[i]) m_flo[i] = 1;
      if (t >= m_hi[i]) m_fhi[i] = 1;
    end
  endtask

  task automatic chk_stat(input string req, input int i);
    logic [31:0] d;
    rd(6'(32 + i), d);
    chk(req, d, exp_stat(i));
  endtask

  task automatic chk_irq(input string req);
    @(negedge clk);
    chk(req, {31'b0, irq}, {31'b0, exp_irq()});
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED_0042));
    m_en = 0; m_ien = 0;
    mdl_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(6'h00, d); chk("R1 ctrl", d, 0);
    rd(6'h01, d); chk("R1 ien", d, 0);
    rd(6'h02, d); chk("R1 ready", d, 0);
    for (int i = 0; i < NS; i++) begin
      chk_stat("R1 status", i);
      rd(6'(16 + i), d); chk("R1 thr", d, 32'h000FFC00);
    end

    // R3 samples ignored while disabled
    samp(0, 100);
    chk_stat("R3 disabled", 0);

    // R2 enables
    wr(6'h00, 32'h1); rd(6'h00, d); chk("R2 ctrl", d, 1);
    wr(6'h01, 32'h1); rd(6'h01, d); chk("R2 ien", d, 1);
    wr(6'h12, 32'd200 | (32'd600 << 10));
    rd(6'h12, d); chk("R2 thr rd", d, exp_thr(2));

    // R7 first reading sets min and max
    samp(2, 400); chk_stat("R7 first", 2);
    chk_irq("R8 quiet");
    // R4 at the lower threshold
    samp(2, 200); chk_stat("R4 equal lower", 2);
    chk_irq("R8 lower");
    // R5 at the upper threshold, R7 new max
    samp(2, 600); chk_stat("R5 equal upper", 2);
    // R7 no new extreme
    samp(2, 300); chk_stat("R7 inside", 2);
    // R6 clear lower only
    wr(6'h12, 32'd200 | (32'd600 << 10) | (32'h1 << 20));
    chk_stat("R6 clear lower", 2);
    chk_irq("R8 upper still set");
    wr(6'h12, 32'd200 | (32'd600 << 10) | (32'h1 << 21));
    chk_stat("R6 clear upper", 2);
    chk_irq("R8 cleared");

    // R8 gating
    wr(6'h01, 32'h0);
    samp(2, 700); chk_stat("R5 above", 2);
    chk_irq("R8 gated");
    wr(6'h01, 32'h1);
    chk_irq("R8 ungated");

    // R10 ready
    rd(6'h02, d); chk("R10 partial", d, 0);
    for (int i = 0; i < NS; i++) samp(i, 500 + i);
    rd(6'h02, d); chk("R10 all seen", d, 1);

    // R11 unmapped
    rd(6'h3F, d); chk("R11 unmapped", d, 0);
    rd(6'(16 + NS), d); chk("R11 bad index", d, 0);
    rd(6'h05, d); chk("R11 glob hole", d, 0);

    // R9 soft reset keeps enables
    wr(6'h00, 32'h3);
    rd(6'h00, d); chk("R9 ctrl", d, 1);
    rd(6'h01, d); chk("R9 ien kept", d, 1);
    rd(6'h02, d); chk("R9 ready", d, 0);
    rd(6'h12, d); chk("R9 thr", d, 32'h000FFC00);
    chk_stat("R9 status", 2);
    chk_irq("R9 irq");

    // R2 max index, extreme values with default window
    samp(NS-1, MAXV); chk_stat("R5 default upper", NS-1);
    samp(NS-1, 0);    chk_stat("R4 default lower", NS-1);

    // random mix
    for (int k = 0; k < 600; k++) begin
      int op = $urandom_range(0, 9);
      int i  = $urandom_range(0, NS-1);
      if (op <= 3) begin
        int t = (op == 3) ? ($urandom_range(0,1) ? m_lo[i] : m_hi[i]) : $urandom_range(0, MAXV);
        samp(i, t);
      end else if (op == 4) begin
        int lo = $urandom_range(0, 500);
        int hi = $urandom_range(400, MAXV);
        wr(6'(16 + i), 32'(lo) | (32'(hi) << 10) | (32'($urandom_range(0, 3)) << 20));
      end else if (op == 5) begin
        chk_stat("R3 random status", i);
      end else if (op == 6) begin
        rd(6'(16 + i), d); chk("R6 random thr", d, exp_thr(i));
      end else if (op == 7) begin
        chk_irq("R8 random irq");
      end else if (op == 8) begin
        rd(6'h02, d); chk("R10 random ready", d, {31'b0, exp_ready()});
      end else begin
        int r = $urandom_range(0, 19);
        if (r == 0)      wr(6'h00, 32'h3);
        else if (r < 4)  wr(6'h00, 32'(r & 1));
        else if (r < 8)  wr(6'h01, 32'(r & 1));
        else             wr(6'h00, 32'h1);
      end
    end
    for (int i = 0; i < NS; i++) chk_stat("R7 final", i);
    chk_irq("R8 final");
    finish_run();
  end
endmodule